// File: doc/BRIEF.md
# Seven-Vote Majority Gate

This block is a purely combinational majority gate over seven single-bit votes. Its output is high exactly when four or more of the seven votes are high. There is no clock, no state and no latency: the result follows the inputs within the same cycle. It is meant to be dropped into a datapath wherever a 4-of-7 threshold is needed, such as redundancy voting or glitch filtering.

Internally the votes are split into a group of four and a group of three. Each group feeds a small counter. Every count bit of these counters is an exclusive-or sum of AND products over the group's votes, and no full-adder chain is used.

- The four-vote counter produces the following bits:
  - `s1`: the parity of the four votes.
  - `s2`: the XOR of the six pairwise products.
  - `s3`: the XOR of the four triple products. It always equals `s1 & s2`.
  - `s4`: the AND of all four votes.
- The count of the four-vote group, read as a binary number, is `{s4,s2,s1}`.
- The three-vote counter produces a parity bit and a carry bit. The carry bit is the majority of the three votes.
- A compare stage decides directly whether the two counts sum to four or more. It does not add them first.

Because the block has no clock and no registers, it has no states and no transitions. The single combinational evaluation path runs from the votes, through the two counters in parallel, and then through the compare stage.

Top module: `maj7_sym`

## Requirements
- R1: For every one of the 128 values of `vote_in`, `maj_out` is 1 exactly when the number of set bits in `vote_in` is 4 or more, and 0 otherwise.
- R2: With `vote_in` = 7'b0000000, `maj_out` is 0.
- R3: With `vote_in` = 7'b1111111, `maj_out` is 1.
- R4: Every one of the 35 patterns with exactly three set bits gives `maj_out` = 0.
- R5: Every one of the 35 patterns with exactly four set bits gives `maj_out` = 1.
- R6: `maj_out` depends only on how many votes are set, not on their positions. Rotating `vote_in` left by one bit position never changes `maj_out`.
- R7: The output is combinational. After a change of `vote_in`, `maj_out` shows the new result without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vote_in | input | 7 | The seven votes; bit i is vote i |
| maj_out | output | 1 | High when at least four votes are high |

## Verification
The block has a fixed width of seven votes, and the bench builds it with the package defaults of a four-vote group and a three-vote group. With those values the whole input space of 128 patterns is small enough to sweep completely. Every pattern is therefore compared against a population count computed in the bench. The sweep also reaches every three-vote and four-vote boundary pattern and every rotation pair.

// File: rtl/maj_pkg.sv
package maj_pkg;
    localparam int VOTES   = 7;
    localparam int LOW_W   = 4;
    localparam int HIGH_W  = VOTES - LOW_W;
    localparam int THRESH  = (VOTES + 1) / 2;
    localparam int SUM_W   = $clog2(VOTES + 1);

    typedef struct packed {
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } sym4_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } sym3_t;
endpackage

// File: rtl/sym_count4.sv
module sym_count4
    import maj_pkg::*;
(
    input  logic [LOW_W-1:0] d,
    output sym4_t            q
);
    logic e1, e2, e3, e4;

    always_comb begin
        e1 = 1'b0;
        e2 = 1'b0;
        e3 = 1'b0;
        for (int i = 0; i < LOW_W; i++) begin
            e1 = e1 ^ d[i];
            for (int j = i + 1; j < LOW_W; j++) begin
                e2 = e2 ^ (d[i] & d[j]);
                for (int k = j + 1; k < LOW_W; k++) begin
                    e3 = e3 ^ (d[i] & d[j] & d[k]);
                end
            end
        end
        e4 = &d;
    end

    always_comb begin
        q.s1 = e1;
        q.s2 = e2;
        q.s3 = e3;
        q.s4 = e4;
    end

    // R1: triple-product sum must coincide with s1 AND s2
    always_comb begin
        a_r1_s3_matches_and: assert (q.s3 == (q.s1 & q.s2))
            else $error("s3 disagrees with s1&s2");
    end

    // R1: a full group of four leaves the low bits clear
    always_comb begin
        a_r1_s4_excludes_low: assert (!(q.s4 && (q.s1 || q.s2)))
            else $error("s4 set together with s1 or s2");
    end

    // R1: the three count bits equal the group's population
    always_comb begin
        a_r1_count4_value: assert ({q.s4, q.s2, q.s1} == 3'($countones(d)))
            else $error("four-vote count wrong");
    end
endmodule

// File: rtl/sym_count3.sv
module sym_count3
    import maj_pkg::*;
(
    input  logic [HIGH_W-1:0] d,
    output sym3_t             q
);
    logic par, pairs;

    always_comb begin
        par   = 1'b0;
        pairs = 1'b0;
        for (int i = 0; i < HIGH_W; i++) begin
            par = par ^ d[i];
            for (int j = i + 1; j < HIGH_W; j++) begin
                pairs = pairs ^ (d[i] & d[j]);
            end
        end
    end

    always_comb begin
        q.sum   = par;
        q.carry = pairs;
    end

    // R1: the two count bits equal the group's population
    always_comb begin
        a_r1_count3_value: assert ({q.carry, q.sum} == 2'($countones(d)))
            else $error("three-vote count wrong");
    end
endmodule

// File: rtl/thresh_cmp.sv
module thresh_cmp
    import maj_pkg::*;
(
    input  sym4_t lo,
    input  sym3_t hi,
    output logic  at_least
);
    // lo count is 4 (s4), or lo in 0..3 plus hi in 0..3 reaching 4
    always_comb begin
        at_least = lo.s4
                 | (lo.s2 & hi.carry)
                 | (lo.s3 & hi.sum)
                 | (lo.s1 & hi.carry & hi.sum);
    end

    // R1: direct compare agrees with an explicit sum of both counts
    always_comb begin
        a_r1_thresh_sum: assert (at_least ==
            (({1'b0, lo.s4, lo.s2, lo.s1} + {2'b00, hi.carry, hi.sum}) >= 4'(THRESH)))
            else $error("threshold compare wrong");
    end
endmodule

// File: rtl/maj7_sym.sv
module maj7_sym
    import maj_pkg::*;
(
    input  logic [VOTES-1:0] vote_in,
    output logic             maj_out
);
    sym4_t lo_cnt;
    sym3_t hi_cnt;

    sym_count4 u_lo (
        .d (vote_in[LOW_W-1:0]),
        .q (lo_cnt)
    );

    sym_count3 u_hi (
        .d (vote_in[VOTES-1:LOW_W]),
        .q (hi_cnt)
    );

    thresh_cmp u_cmp (
        .lo       (lo_cnt),
        .hi       (hi_cnt),
        .at_least (maj_out)
    );

    // R1, R4, R5: output follows the population threshold
    always_comb begin
        a_r1_majority: assert (maj_out == ($countones(vote_in) >= THRESH))
            else $error("majority output wrong");
    end
endmodule

// File: tb/sim_maj7_sym.sv
module sim_maj7_sym;
    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic [6:0] vote_in;
    logic       maj_out;
    int         checks;
    int         errors;
    logic       done;
    logic       res [128];

    maj7_sym u0 (
        .vote_in (vote_in),
        .maj_out (maj_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp, input int pat);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pattern %07b actual %0b expected %0b", req, pat[6:0], act, exp);
        end
    endtask

    initial begin
        checks  = 0;
        errors  = 0;
        done    = 1'b0;
        vote_in = '0;
        @(posedge clk);
        @(negedge clk);
        check("R2", maj_out, 1'b0, 0);

        // R1, R4, R5: full sweep against popcount
        for (int v = 0; v < 128; v++) begin
            @(posedge clk);
            vote_in = 7'(v);
            @(negedge clk);
            res[v] = maj_out;
            check("R1", maj_out, ($countones(7'(v)) >= 4), v);
            if ($countones(7'(v)) == 3) check("R4", maj_out, 1'b0, v);
            if ($countones(7'(v)) == 4) check("R5", maj_out, 1'b1, v);
        end

        @(posedge clk);
        vote_in = 7'b1111111;
        @(negedge clk);
        check("R3", maj_out, 1'b1, 127);

        // R6: rotation invariance
        for (int v = 0; v < 128; v++) begin
            logic [6:0] p;
            logic [6:0] r;
            p = 7'(v);
            r = {p[5:0], p[6]};
            check("R6", res[r], res[v], v);
        end

        // R7: output moves with no clock edge in between
        @(negedge clk);
        vote_in = 7'b0001111;
        #1;
        check("R7", maj_out, 1'b1, 15);
        vote_in = 7'b0000111;
        #1;
        check("R7", maj_out, 1'b0, 7);
        vote_in = 7'b1110000;
        #1;
        check("R7", maj_out, 1'b0, 112);
        vote_in = 7'b1110001;
        #1;
        check("R7", maj_out, 1'b1, 113);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule